// File: doc/BRIEF.md
# Enabled Three-Bit Gray-Order Stepper

This block is a Moore state machine that walks a fixed loop of eight 3-bit codes, in which each code differs from the one before it in exactly one bit. The loop is 000, 010, 011, 001, 101, 111, 110, 100, and after 100 it returns to 000. The machine moves one position along the loop on each rising clock edge where the step enable is high. On any edge where the enable is low, it stays where it is.

The 3-bit output is the state register itself, so the output has no combinational decode after the flops and cannot glitch. All eight codes belong to the loop, so no state is unreachable. A synchronous reset returns the machine to 000, and reset takes priority over the enable.

The eight states are named by their position in the loop:

| State | Code |
|-------|------|
| ST_P0 | 000 |
| ST_P1 | 010 |
| ST_P2 | 011 |
| ST_P3 | 001 |
| ST_P4 | 101 |
| ST_P5 | 111 |
| ST_P6 | 110 |
| ST_P7 | 100 |

There are two kinds of transition:
- An advance moves ST_Pk to ST_P(k+1). The advance from ST_P7 goes back to ST_P0.
- A hold keeps every state in place when the enable is low.

Top module: `gray_seq_fsm`

## Requirements
- R1: A clock edge with `rst` high sets `code_o` to 3'b000, whatever the value of `step_en`.
- R2: With `step_en` high on every edge, `code_o` moves from 000 through 010, 011, 001, 101, 111, 110 and 100, one code per edge. Bit 2 of `code_o` is the leftmost bit of each code.
- R3: An edge with `step_en` low and `rst` low leaves `code_o` unchanged.
- R4: Every change of `code_o` outside reset flips exactly one bit.
- R5: An enabled edge while `code_o` is 100 returns `code_o` to 000.
- R6: Starting from any code, eight enabled edges bring `code_o` back to that same code.
- R7: When enabled and disabled edges are interleaved, the position in the loop moves forward by exactly the number of enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance by one position on this edge |
| code_o | output | 3 | Current code, taken directly from the state register |

## Verification
The bench first runs the whole loop and checks the step from 100 back to 000. A design that stopped at 100 would fail there, as would one that went on to the reflected-code order. It then holds `step_en` low for several edges in the middle of the loop, which exposes any design that drifts, or that ignores the enable on some states. Reset is asserted with the enable high to catch a design that gives the enable priority. Finally, a mixed pattern of enable edges finds a design that counts two steps per edge, or that loses a step after an idle edge.

// File: rtl/gray_seq_pkg.sv
package gray_seq_pkg;
    localparam int CODE_W = 3;
    localparam int N_POS  = 1 << CODE_W;

    typedef enum logic [CODE_W-1:0] {
        ST_P0 = 3'b000,
        ST_P1 = 3'b010,
        ST_P2 = 3'b011,
        ST_P3 = 3'b001,
        ST_P4 = 3'b101,
        ST_P5 = 3'b111,
        ST_P6 = 3'b110,
        ST_P7 = 3'b100
    } pos_t;
endpackage

// File: rtl/gray_seq_next.sv
module gray_seq_next
    import gray_seq_pkg::*;
(
    input  pos_t cur_i,
    input  logic adv_i,
    output pos_t nxt_o
);
    pos_t succ;

    // Successor along the loop
    always_comb begin
        unique case (cur_i)
            ST_P0:   succ = ST_P1;
            ST_P1:   succ = ST_P2;
            ST_P2:   succ = ST_P3;
            ST_P3:   succ = ST_P4;
            ST_P4:   succ = ST_P5;
            ST_P5:   succ = ST_P6;
            ST_P6:   succ = ST_P7;
            ST_P7:   succ = ST_P0;
            default: succ = ST_P0;
        endcase
    end

    // Hold transition when the enable is low
    always_comb begin
        nxt_o = adv_i ? succ : cur_i;
    end
endmodule

// File: rtl/gray_seq_out.sv
module gray_seq_out
    import gray_seq_pkg::*;
(
    input  pos_t                    st_i,
    output logic [CODE_W-1:0]       code_o
);
    // Moore output: the state encoding is the code itself
    always_comb begin
        code_o = st_i;
    end
endmodule

// File: rtl/gray_seq_fsm.sv
module gray_seq_fsm
    import gray_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    output logic [CODE_W-1:0] code_o
);
    pos_t st_q;
    pos_t st_d;

    gray_seq_next u_next (
        .cur_i (st_q),
        .adv_i (step_en),
        .nxt_o (st_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_P0;
        end else begin
            st_q <= st_d;
        end
    end

    // Output process
    gray_seq_out u_out (
        .st_i   (st_q),
        .code_o (code_o)
    );
endmodule

// File: rtl/gray_seq_fsm_chk.sv
module gray_seq_fsm_chk
    import gray_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic [CODE_W-1:0] code_o
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
        end
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (code_o == 3'b000));

    p_first_step_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        (step_en && code_o == 3'b000) |=> (code_o == 3'b010));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        !step_en |=> $stable(code_o));

    p_one_bit_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        step_en |=> ($countones(code_o ^ $past(code_o)) == 1));

    p_wrap_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        (step_en && code_o == 3'b100) |=> (code_o == 3'b000));
endmodule

bind gray_seq_fsm gray_seq_fsm_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .code_o  (code_o)
);

// File: tb/test_gray_seq_fsm.sv
module test_gray_seq_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [2:0] code_o;
    int         n_chk = 0;
    int         n_bad = 0;
    int         pos = 0;
    logic [2:0] loop_tab [8];

    always #4 clk = ~clk;

    gray_seq_fsm i_gray_seq_fsm (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .code_o  (code_o)
    );

    task automatic check(input string req, input logic [2:0] exp);
        n_chk++;
        if (code_o !== exp) begin
            n_bad++;
            $display("FAIL %s: code_o=%b expected=%b", req, code_o, exp);
        end
    endtask

    // One edge with the given inputs; sampled at the next falling edge
    task automatic edge_step(input logic r, input logic e);
        rst = r;
        step_en = e;
        @(negedge clk);
        if (r) begin
            pos = 0;
        end else if (e) begin
            pos = (pos + 1) % 8;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        edge_step(1'b1, 1'b0);
        check("R1 reset", 3'b000);
    endtask

    task automatic t_full_loop;
        for (int i = 1; i <= 8; i++) begin
            edge_step(1'b0, 1'b1);
            if (i == 8) begin
                check("R5 wrap", 3'b000);
            end else begin
                check("R2 order", loop_tab[i]);
            end
        end
    endtask

    task automatic t_hold;
        edge_step(1'b0, 1'b1);
        edge_step(1'b0, 1'b1);
        edge_step(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            edge_step(1'b0, 1'b0);
            check("R3 hold", loop_tab[3]);
        end
    endtask

    task automatic t_one_bit;
        logic [2:0] prev;
        for (int i = 0; i < 8; i++) begin
            prev = code_o;
            edge_step(1'b0, 1'b1);
            n_chk++;
            if ($countones(prev ^ code_o) != 1) begin
                n_bad++;
                $display("FAIL R4 one bit: code_o=%b expected one flip from %b", code_o, prev);
            end
        end
    endtask

    task automatic t_period;
        logic [2:0] start;
        start = code_o;
        for (int i = 0; i < 8; i++) begin
            edge_step(1'b0, 1'b1);
        end
        check("R6 period", start);
    endtask

    task automatic t_reset_priority;
        edge_step(1'b0, 1'b1);
        edge_step(1'b1, 1'b1);
        check("R1 reset over enable", 3'b000);
    endtask

    task automatic t_mixed;
        logic [7:0] pat = 8'b1011_0110;
        edge_step(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            edge_step(1'b0, pat[i]);
            check("R7 mixed", loop_tab[pos]);
        end
        for (int i = 0; i < 5; i++) begin
            edge_step(1'b0, i[0]);
            check("R7 mixed", loop_tab[pos]);
        end
    endtask

    initial begin
        loop_tab[0] = 3'b000; loop_tab[1] = 3'b010;
        loop_tab[2] = 3'b011; loop_tab[3] = 3'b001;
        loop_tab[4] = 3'b101; loop_tab[5] = 3'b111;
        loop_tab[6] = 3'b110; loop_tab[7] = 3'b100;
        t_reset();
        t_full_loop();
        t_hold();
        t_one_bit();
        t_period();
        t_reset_priority();
        t_mixed();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: code_o=%b expected=end of run", code_o);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule